// File: doc/BRIEF.md
# Dual-Access Memory Conflict Splitter

This block sits between a core's two data-access lanes and the data memory. A parallel instruction can issue two accesses in one cycle, for example one load and one store. When the two addresses fall in the same physical slice of memory, both cannot be served in one cycle. The block compares the two addresses and decides whether the pair goes out together or is split into two consecutive cycles.

Two memory regions are recognised by comparing an upper address field against two tag inputs. Inside a region, a clash needs all of the following to be equal in both addresses:
- the half-region bit (bit 16);
- the sub-bank pair (bits 13 and 12);
- the 32-bit word polarity bit (bit 2).

On a clash the block does three things in the first cycle:
- raises a conflict flag;
- raises a stall for that one cycle;
- forwards access 0 on lane 0.

It also keeps a copy of the access 1 address. In the following cycle it issues that stored address on lane 1. During that second cycle the requesters must hold, and the block ignores whatever is on its request inputs.

Top module: `dmem_pair_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls with no valid request, `second`, `stall` and `conflict` are 0 and both lanes are idle.
- R2: Address bits [TAG_LSB+TAG_W-1:TAG_LSB] (default [31:20]) select the region. If they equal `region_a_tag` the access is in region A. Otherwise, if they equal `region_b_tag`, it is in region B. A match on `region_a_tag` wins when both tags are equal. An access in neither region never produces a conflict.
- R3: A conflict needs both accesses in the same region with bit 16, bits 13:12 and bit 2 all equal. If any one of these differs, or the regions differ, there is no conflict. All other address bits have no influence.
- R4: If `a0_vld` or `a1_vld` is low, `conflict` stays 0.
- R5: With no conflict and not in a second cycle, the lanes follow the requests in the same cycle, with `stall` at 0:
  - `lane0_vld` = `a0_vld` and `lane1_vld` = `a1_vld`;
  - each lane's address equals its request address when that lane is valid, and is 0 when it is idle.
- R6: In a conflicting cycle, `conflict` and `stall` are 1, lane 0 carries access 0, and lane 1 is idle with address 0.
- R7: In the cycle after a conflict, `second` is 1 and `stall` and `conflict` are 0. Lane 1 carries the access 1 address captured in the conflict cycle, and lane 0 is idle. The request inputs in that cycle have no effect on any output.
- R8: `second` lasts exactly one cycle, after which requests are evaluated again, so back-to-back conflicting pairs each take two cycles.
- R9: With region tag 0xFF8, the addresses 0xFF801344 and 0xFF801994 form a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a0_vld | input | 1 | Access 0 request valid |
| a0_addr | input | ADDR_W | Access 0 byte address |
| a1_vld | input | 1 | Access 1 request valid |
| a1_addr | input | ADDR_W | Access 1 byte address |
| region_a_tag | input | TAG_W | Upper-field value that selects region A |
| region_b_tag | input | TAG_W | Upper-field value that selects region B |
| conflict | output | 1 | Current pair clashes and is being split |
| stall | output | 1 | One-cycle hold request to the issuing pipeline |
| second | output | 1 | Second cycle of a split pair |
| lane0_vld | output | 1 | Lane 0 carries an access this cycle |
| lane0_addr | output | ADDR_W | Lane 0 address, 0 when idle |
| lane1_vld | output | 1 | Lane 1 carries an access this cycle |
| lane1_addr | output | ADDR_W | Lane 1 address, 0 when idle |

## Verification
The only internal state is the split-phase bit and the stored access 1 address. A stuck or mis-set phase bit shows up at the ports within one cycle, in either of two ways:
- a missing or doubled `second`;
- both lanes live together after a stall.

A stored address that is taken at the wrong moment appears on `lane1_addr` in the cycle right after the stall. The bench therefore drives unrelated request values during every second cycle, so that a design that leaks the live inputs differs at once.

The comparison logic is exercised in two ways:
- by flipping each participating address bit one at a time from a known clashing pair;
- by flipping non-participating bits, which must not change the outcome.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // Address bit positions whose equality defines a physical clash.
    localparam int HALF_BIT = 16;
    localparam int SUB_HI   = 13;
    localparam int SUB_LO   = 12;
    localparam int POL_BIT  = 2;

    typedef enum logic [1:0] {
        REGION_NONE = 2'd0,
        REGION_A    = 2'd1,
        REGION_B    = 2'd2
    } region_e;

    typedef struct packed {
        logic       live;
        region_e    region;
        logic       half;
        logic [1:0] sub;
        logic       pol;
    } slot_key_t;

    typedef enum logic {
        SEQ_OPEN   = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_state_e;

    function automatic logic keys_clash(input slot_key_t k0, input slot_key_t k1);
        logic same_slice;
        same_slice = (k0.half == k1.half) && (k0.sub == k1.sub) && (k0.pol == k1.pol);
        return k0.live && k1.live && (k0.region != REGION_NONE)
            && (k0.region == k1.region) && same_slice;
    endfunction

endpackage

// File: rtl/dpc_slot_decode.sv
module dpc_slot_decode
    import dpc_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             live,
    input  logic [TAG_W-1:0] tag_field,
    input  logic             half_sel,
    input  logic [1:0]       sub_sel,
    input  logic             word_pol,
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output slot_key_t        key
);

    region_e region;

    always_comb begin
        if (tag_field == tag_a) begin
            region = REGION_A;
        end else if (tag_field == tag_b) begin
            region = REGION_B;
        end else begin
            region = REGION_NONE;
        end
    end

    always_comb begin
        key        = '0;
        key.live   = live;
        key.region = region;
        key.half   = half_sel;
        key.sub    = sub_sel;
        key.pol    = word_pol;
    end

endmodule

// File: rtl/dpc_clash_cmp.sv
module dpc_clash_cmp
    import dpc_pkg::*;
(
    input  slot_key_t key0,
    input  slot_key_t key1,
    output logic      clash
);

    always_comb begin
        clash = keys_clash(key0, key1);
    end

endmodule

// File: rtl/dpc_pair_seq.sv
module dpc_pair_seq
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clash,
    input  logic              live0,
    input  logic [ADDR_W-1:0] addr0,
    input  logic              live1,
    input  logic [ADDR_W-1:0] addr1,
    output logic              conflict,
    output logic              stall,
    output logic              second,
    output logic              lane0_vld,
    output logic [ADDR_W-1:0] lane0_addr,
    output logic              lane1_vld,
    output logic [ADDR_W-1:0] lane1_addr
);

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [ADDR_W-1:0] held_q;
    logic              split_now;

    assign split_now = (state_q == SEQ_OPEN) && clash;

    always_comb begin
        case (state_q)
            SEQ_OPEN:   state_d = split_now ? SEQ_SECOND : SEQ_OPEN;
            SEQ_SECOND: state_d = SEQ_OPEN;
            default:    state_d = SEQ_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OPEN;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (split_now) begin
                held_q <= addr1;
            end
        end
    end

    always_comb begin
        conflict   = split_now;
        stall      = split_now;
        second     = (state_q == SEQ_SECOND);
        lane0_vld  = 1'b0;
        lane0_addr = '0;
        lane1_vld  = 1'b0;
        lane1_addr = '0;
        if (state_q == SEQ_SECOND) begin
            lane1_vld  = 1'b1;
            lane1_addr = held_q;
        end else begin
            lane0_vld  = live0;
            lane0_addr = live0 ? addr0 : '0;
            lane1_vld  = live1 && !clash;
            lane1_addr = (live1 && !clash) ? addr1 : '0;
        end
    end

endmodule

// File: rtl/dmem_pair_arbiter.sv
module dmem_pair_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TAG_LSB = 20,
    parameter int TAG_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a0_vld,
    input  logic [ADDR_W-1:0] a0_addr,
    input  logic              a1_vld,
    input  logic [ADDR_W-1:0] a1_addr,
    input  logic [TAG_W-1:0]  region_a_tag,
    input  logic [TAG_W-1:0]  region_b_tag,
    output logic              conflict,
    output logic              stall,
    output logic              second,
    output logic              lane0_vld,
    output logic [ADDR_W-1:0] lane0_addr,
    output logic              lane1_vld,
    output logic [ADDR_W-1:0] lane1_addr
);

    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;
    localparam int NUM_REQ = 2;

    logic [ADDR_W-1:0] req_addr [NUM_REQ];
    logic              req_live [NUM_REQ];
    slot_key_t         key      [NUM_REQ];
    logic              clash;

    assign req_addr[0] = a0_addr;
    assign req_addr[1] = a1_addr;
    assign req_live[0] = a0_vld;
    assign req_live[1] = a1_vld;

    generate
        for (genvar g = 0; g < NUM_REQ; g++) begin : g_dec
            dpc_slot_decode #(
                .TAG_W (TAG_W)
            ) u_dec (
                .live      (req_live[g]),
                .tag_field (req_addr[g][TAG_MSB:TAG_LSB]),
                .half_sel  (req_addr[g][HALF_BIT]),
                .sub_sel   (req_addr[g][SUB_HI:SUB_LO]),
                .word_pol  (req_addr[g][POL_BIT]),
                .tag_a     (region_a_tag),
                .tag_b     (region_b_tag),
                .key       (key[g])
            );
        end
    endgenerate

    dpc_clash_cmp u_cmp (
        .key0  (key[0]),
        .key1  (key[1]),
        .clash (clash)
    );

    dpc_pair_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .clash      (clash),
        .live0      (a0_vld),
        .addr0      (a0_addr),
        .live1      (a1_vld),
        .addr1      (a1_addr),
        .conflict   (conflict),
        .stall      (stall),
        .second     (second),
        .lane0_vld  (lane0_vld),
        .lane0_addr (lane0_addr),
        .lane1_vld  (lane1_vld),
        .lane1_addr (lane1_addr)
    );

endmodule

// File: rtl/dmem_pair_arbiter_chk.sv
module dmem_pair_arbiter_chk #(
    parameter int ADDR_W  = 32,
    parameter int TAG_LSB = 20,
    parameter int TAG_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              a0_vld,
    input logic [ADDR_W-1:0] a0_addr,
    input logic              a1_vld,
    input logic [ADDR_W-1:0] a1_addr,
    input logic [TAG_W-1:0]  region_a_tag,
    input logic [TAG_W-1:0]  region_b_tag,
    input logic              conflict,
    input logic              stall,
    input logic              second,
    input logic              lane0_vld,
    input logic [ADDR_W-1:0] lane0_addr,
    input logic              lane1_vld,
    input logic [ADDR_W-1:0] lane1_addr
);

    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

    logic a0_outside;

    assign a0_outside = (a0_addr[TAG_MSB:TAG_LSB] != region_a_tag)
                     && (a0_addr[TAG_MSB:TAG_LSB] != region_b_tag);

    // R2: accesses outside both regions never clash
    a_r2_outside_quiet: assert property (@(posedge clk) disable iff (rst)
        a0_outside |-> !conflict);

    // R4: a missing request never clashes
    a_r4_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
        (!a0_vld || !a1_vld) |-> !conflict);

    // R5: clean pairs pass straight through
    a_r5_passthru: assert property (@(posedge clk) disable iff (rst)
        (!second && !conflict) |-> (lane0_vld == a0_vld) && (lane1_vld == a1_vld) && !stall);

    // R6: in a clash cycle only lane 0 is used
    a_r6_first_half: assert property (@(posedge clk) disable iff (rst)
        stall |-> lane0_vld && !lane1_vld && (lane0_addr == a0_addr));

    // R7: the cycle after a stall serves the stored access 1
    a_r7_second_half: assert property (@(posedge clk) disable iff (rst)
        stall |=> second && lane1_vld && !lane0_vld && !stall && !conflict);

    a_r7_held_address: assert property (@(posedge clk) disable iff (rst)
        stall |=> (lane1_addr == $past(a1_addr)));

    // R8: the split phase lasts one cycle only
    a_r8_single_second: assert property (@(posedge clk) disable iff (rst)
        second |=> !second);

endmodule

bind dmem_pair_arbiter dmem_pair_arbiter_chk #(
    .ADDR_W  (ADDR_W),
    .TAG_LSB (TAG_LSB),
    .TAG_W   (TAG_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .a0_vld       (a0_vld),
    .a0_addr      (a0_addr),
    .a1_vld       (a1_vld),
    .a1_addr      (a1_addr),
    .region_a_tag (region_a_tag),
    .region_b_tag (region_b_tag),
    .conflict     (conflict),
    .stall        (stall),
    .second       (second),
    .lane0_vld    (lane0_vld),
    .lane0_addr   (lane0_addr),
    .lane1_vld    (lane1_vld),
    .lane1_addr   (lane1_addr)
);

// File: tb/dmem_pair_arbiter_tb_top.sv
module dmem_pair_arbiter_tb_top;

    localparam int ADDR_W  = 32;
    localparam int TAG_LSB = 20;
    localparam int TAG_W   = 12;
    localparam int TAG_MSB = TAG_LSB + TAG_W - 1;
    localparam logic [31:0] SLICE_BITS = 32'h0001_3004;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a0_vld = 1'b0;
    logic [ADDR_W-1:0] a0_addr = '0;
    logic              a1_vld = 1'b0;
    logic [ADDR_W-1:0] a1_addr = '0;
    logic [TAG_W-1:0]  region_a_tag = 12'hFF8;
    logic [TAG_W-1:0]  region_b_tag = 12'hFF9;
    logic              conflict, stall, second, lane0_vld, lane1_vld;
    logic [ADDR_W-1:0] lane0_addr, lane1_addr;

    int n_tests = 0;
    int n_fail  = 0;

    logic              m_second = 1'b0;
    logic [ADDR_W-1:0] m_held   = '0;

    always #5 clk = ~clk;

    dmem_pair_arbiter #(
        .ADDR_W  (ADDR_W),
        .TAG_LSB (TAG_LSB),
        .TAG_W   (TAG_W)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .a0_vld       (a0_vld),
        .a0_addr      (a0_addr),
        .a1_vld       (a1_vld),
        .a1_addr      (a1_addr),
        .region_a_tag (region_a_tag),
        .region_b_tag (region_b_tag),
        .conflict     (conflict),
        .stall        (stall),
        .second       (second),
        .lane0_vld    (lane0_vld),
        .lane0_addr   (lane0_addr),
        .lane1_vld    (lane1_vld),
        .lane1_addr   (lane1_addr)
    );

    function automatic int region_of(logic [ADDR_W-1:0] a, logic [TAG_W-1:0] ta, logic [TAG_W-1:0] tb);
        if (a[TAG_MSB:TAG_LSB] == ta) return 1;
        if (a[TAG_MSB:TAG_LSB] == tb) return 2;
        return 0;
    endfunction

    function automatic logic model_clash(logic v0, logic [ADDR_W-1:0] x0, logic v1, logic [ADDR_W-1:0] x1,
                                         logic [TAG_W-1:0] ta, logic [TAG_W-1:0] tb);
        int r0, r1;
        r0 = region_of(x0, ta, tb);
        r1 = region_of(x1, ta, tb);
        return v0 && v1 && (r0 != 0) && (r0 == r1) && (x0[16] == x1[16])
            && (x0[13:12] == x1[13:12]) && (x0[2] == x1[2]);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle, check every output against the model, advance the model.
    task automatic step(string req, logic v0, logic [ADDR_W-1:0] x0, logic v1, logic [ADDR_W-1:0] x1);
        logic c;
        @(negedge clk);
        a0_vld = v0; a0_addr = x0; a1_vld = v1; a1_addr = x1;
        #2;
        if (m_second) begin
            chk(req, "R7 conflict", {31'd0, conflict}, 32'd0);
            chk(req, "R7 stall", {31'd0, stall}, 32'd0);
            chk(req, "R7 second", {31'd0, second}, 32'd1);
            chk(req, "R7 lane0_vld", {31'd0, lane0_vld}, 32'd0);
            chk(req, "R7 lane0_addr", lane0_addr, 32'd0);
            chk(req, "R7 lane1_vld", {31'd0, lane1_vld}, 32'd1);
            chk(req, "R7 lane1_addr", lane1_addr, m_held);
            m_second = 1'b0;
        end else begin
            c = model_clash(v0, x0, v1, x1, region_a_tag, region_b_tag);
            chk(req, "R3 conflict", {31'd0, conflict}, {31'd0, c});
            chk(req, "R6 stall", {31'd0, stall}, {31'd0, c});
            chk(req, "R8 second", {31'd0, second}, 32'd0);
            chk(req, "R5 lane0_vld", {31'd0, lane0_vld}, {31'd0, v0});
            chk(req, "R5 lane0_addr", lane0_addr, v0 ? x0 : 32'd0);
            chk(req, "R6 lane1_vld", {31'd0, lane1_vld}, {31'd0, v1 && !c});
            chk(req, "R6 lane1_addr", lane1_addr, (v1 && !c) ? x1 : 32'd0);
            if (c) begin
                m_second = 1'b1;
                m_held   = x1;
            end
        end
    endtask

    task automatic expect_clash(string req, logic exp);
        chk(req, "conflict", {31'd0, conflict}, {31'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] base0, base1;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (2) @(negedge clk);
        #2;
        chk("R1", "second in reset", {31'd0, second}, 32'd0);
        chk("R1", "stall in reset", {31'd0, stall}, 32'd0);
        chk("R1", "conflict in reset", {31'd0, conflict}, 32'd0);
        chk("R1", "lane1_vld in reset", {31'd0, lane1_vld}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        step("R1", 1'b0, '0, 1'b0, '0);

        // R9: the example pair, then its second cycle with unrelated inputs (R7)
        base0 = 32'hFF80_1344;
        base1 = 32'hFF80_1994;
        step("R9", 1'b1, base0, 1'b1, base1);
        step("R7", 1'b1, 32'h1234_5678, 1'b1, 32'h9ABC_DEF0);

        // R3: flipping any one slice bit removes the clash; other bits do not matter
        step("R3", 1'b1, base0, 1'b1, base1 ^ 32'h0001_0000);
        step("R3", 1'b1, base0, 1'b1, base1 ^ 32'h0000_2000);
        step("R3", 1'b1, base0, 1'b1, base1 ^ 32'h0000_1000);
        step("R3", 1'b1, base0, 1'b1, base1 ^ 32'h0000_0004);
        step("R3", 1'b1, base0, 1'b1, base1 ^ 32'h000E_CFFB);
        step("R3", 1'b0, '0, 1'b0, '0);

        // R2: region B clashes, A against B and outside do not
        step("R2", 1'b1, 32'hFF90_0010, 1'b1, 32'hFF90_0810);
        step("R2", 1'b0, '0, 1'b0, '0);
        step("R2", 1'b1, 32'hFF80_0010, 1'b1, 32'hFF90_0010);
        step("R2", 1'b1, 32'h1230_0010, 1'b1, 32'h1230_0010);
        region_a_tag = 12'hABC; region_b_tag = 12'hABC;
        step("R2", 1'b1, 32'hABC0_0004, 1'b1, 32'hABCF_0C04 & 32'hFFFE_FFFF);
        step("R2", 1'b0, '0, 1'b0, '0);
        region_a_tag = 12'hFF8; region_b_tag = 12'hFF9;

        // R4: one side not valid
        step("R4", 1'b0, base0, 1'b1, base1);
        step("R4", 1'b1, base0, 1'b0, base1);

        // R8: back-to-back clashing pairs
        step("R8", 1'b1, base0, 1'b1, base1);
        step("R8", 1'b1, base0, 1'b1, base1);
        step("R8", 1'b1, 32'hFF90_0000, 1'b1, 32'hFF90_0000);
        expect_clash("R8", 1'b1);
        step("R8", 1'b0, '0, 1'b0, '0);

        // Random mix, biased towards near-clashing pairs
        for (int i = 0; i < 4000; i++) begin
            logic [TAG_W-1:0] t0, t1;
            logic [31:0] mask, x0, x1;
            int sel;
            sel = $urandom % 4;
            t0 = (sel < 2) ? region_a_tag : (sel == 2) ? region_b_tag : TAG_W'($urandom);
            sel = $urandom % 5;
            t1 = (sel < 3) ? t0 : (sel == 3) ? region_b_tag : TAG_W'($urandom);
            x0 = {t0, 20'($urandom)};
            mask = $urandom & 32'h000F_FFFF;
            if (($urandom % 2) == 0) mask = mask & ~SLICE_BITS;
            x1 = {t1, x0[19:0] ^ mask[19:0]};
            step("R5", ($urandom % 8) != 0, x0, ($urandom % 8) != 0, x1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule